// File: doc/BRIEF.md
# Interrupt Request Routing Crossbar

This block sits in front of an interrupt controller whose input count is smaller than the number of interrupt request lines that the peripherals produce. Each controller input (an "output" of this block) has its own routing register. That register holds the index of the source request line that drives the output. Software programs the registers through a simple memory-mapped register port. The registers sit at consecutive byte offsets, one register size apart. The register size is 1, 2 or 4 bytes, and partial writes with byte enables are supported.

Outputs come in three kinds, and a parameter mask fixes the kind of each one. A routed output follows the source named by its register. A reserved output has no storage and passes a dedicated hard-wired request straight through. A skipped output has a register that can be written and read back, but the output still follows its hard-wired request. Every register resets to a safe source index, a parameter that defaults to 0. A write that would store an index outside the source range is dropped. Each output is registered once, so a change on a source line appears at the output exactly one clock later.

Top module: `irq_xbar`

## Requirements
- R1: During reset, every bit of `irq_out` is 0. After reset, every routing register reads back the safe index SAFE_IDX (default 0), so routed outputs follow source SAFE_IDX.
- R2: A routed output `irq_out[i]` equals `src_irq[k]` as sampled at the previous rising clock edge, where k is the index held in register i. A change on a source is therefore visible one clock later and not earlier.
- R3: A write to byte address i*REG_BYTES with all byte enables set stores the written index in register i. A read of that address returns the index zero-extended to REG_BYTES*8 bits on `bus_rdata`. The read is combinational from `bus_addr`. A write strobes at most one register.
- R4: A write whose resulting register value is NUM_SRC (default 400) or larger is ignored, and the register keeps its previous value.
- R5: Byte enable bit b (byte lane b = `bus_wdata[8b+7:8b]`) updates only byte b of the addressed register. The other bytes keep their stored value. The check of R4 applies to the merged value.
- R6: Reserved outputs (default 0, 1, 2, 3, 5, 6, 131, 132) drive `hw_irq[i]` delayed by one clock. Writes to their address have no effect, their reads return 0, and the sources have no influence on them.
- R7: Skipped outputs (default 10, 133, 139, 140) store and read back written indices like routed ones, but their output still drives `hw_irq[i]` delayed by one clock, whatever the register holds.
- R8: A write to an address that is not a multiple of REG_BYTES, or that lies at or beyond NUM_OUT*REG_BYTES, changes no register. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Peripheral request lines, index k is source k |
| hw_irq | input | NUM_OUT | Hard-wired requests for reserved and skipped outputs |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | REG_BYTES*8 | Write data |
| bus_be | input | REG_BYTES | Byte enables of the write |
| bus_rdata | output | REG_BYTES*8 | Read data for `bus_addr` |
| irq_out | output | NUM_OUT | Registered requests to the interrupt controller |

## Verification
Routing is tried with the source lines all low, all high, and alternating. It is also tried with a single line high at index 0, 7, 250 and at the top index 399. Single-hot patterns tell apart registers that point at neighbouring sources, and they expose truncated index bits. The all-high and all-low patterns show that bypassed outputs ignore the sources. Moving the hard-wired lines against fixed sources tells the reserved and skipped paths apart from the routed ones. One-clock checks placed just before and just after an edge fix the latency. Byte-lane writes are chosen so that one merged value is legal and a later one crosses the source count, which shows that the range check is applied after the merge.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  localparam int MAX_OUT = 1024;

  // Merge write lanes into the current register value, lane by lane.
  function automatic logic [31:0] merge_bytes(input logic [31:0] cur,
                                              input logic [31:0] wdat,
                                              input logic [3:0]  be,
                                              input int          nbytes);
    logic [31:0] res;
    res = cur;
    for (int b = 0; b < 4; b++) begin
      if (b < nbytes && be[b]) res[8*b +: 8] = wdat[8*b +: 8];
    end
    return res;
  endfunction

  // A stored index must name an existing source.
  function automatic logic index_ok(input logic [31:0] val, input int nsrc);
    return val < 32'(nsrc);
  endfunction

  function automatic logic [MAX_OUT-1:0] ref_rsv_mask();
    logic [MAX_OUT-1:0] m;
    m = '0;
    m[0] = 1'b1; m[1] = 1'b1; m[2] = 1'b1; m[3] = 1'b1;
    m[5] = 1'b1; m[6] = 1'b1; m[131] = 1'b1; m[132] = 1'b1;
    return m;
  endfunction

  function automatic logic [MAX_OUT-1:0] ref_skip_mask();
    logic [MAX_OUT-1:0] m;
    m = '0;
    m[10] = 1'b1; m[133] = 1'b1; m[139] = 1'b1; m[140] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/xbar_regbank.sv
module xbar_regbank #(
  parameter int NUM_OUT   = 160,
  parameter int NUM_SRC   = 400,
  parameter int REG_BYTES = 2,
  parameter int SAFE_IDX  = 0,
  parameter logic [NUM_OUT-1:0] RSV = '0,
  localparam int DATA_W = REG_BYTES * 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int OUT_W  = $clog2(NUM_OUT),
  localparam int ADDR_W = $clog2(NUM_OUT * REG_BYTES) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [REG_BYTES-1:0]          bus_be,
  output logic [DATA_W-1:0]             bus_rdata,
  output logic [NUM_OUT-1:0]            reg_we,
  output logic [NUM_OUT-1:0][IDX_W-1:0] route_idx
);

  logic [ADDR_W-1:0] ridx;
  logic [OUT_W-1:0]  ridx_n;
  logic              aligned;
  logic              hit;
  logic [IDX_W-1:0]  cur;
  logic [31:0]       merged;
  logic              wr_go;

  always_comb begin
    aligned = (32'(bus_addr) % REG_BYTES) == 0;
    ridx    = ADDR_W'(32'(bus_addr) / REG_BYTES);
    hit     = aligned && (32'(ridx) < NUM_OUT);
    ridx_n  = hit ? OUT_W'(ridx) : '0;
    cur     = hit ? route_idx[ridx_n] : '0;
    merged  = xbar_pkg::merge_bytes(32'(cur), 32'(bus_wdata), 4'(bus_be), REG_BYTES);
    wr_go   = bus_wr && hit && !RSV[ridx_n] && xbar_pkg::index_ok(merged, NUM_SRC);
    bus_rdata = (hit && !RSV[ridx_n]) ? DATA_W'(cur) : '0;
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_reg
    assign reg_we[i] = wr_go && (ridx_n == OUT_W'(i));
    if (RSV[i]) begin : g_none
      assign route_idx[i] = '0;
    end else begin : g_store
      logic [IDX_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= IDX_W'(SAFE_IDX);
        else if (reg_we[i]) q <= IDX_W'(merged);
      end
      assign route_idx[i] = q;
    end
  end

endmodule

// File: rtl/xbar_lane.sv
module xbar_lane #(
  parameter int   NUM_SRC = 400,
  parameter logic BYPASS  = 1'b0,
  localparam int  IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               hw_req,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic               out_q
);

  logic pick;

  assign pick = BYPASS ? hw_req : src_irq[sel_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= pick;
  end

endmodule

// File: rtl/irq_xbar.sv
module irq_xbar #(
  parameter int NUM_OUT   = 160,
  parameter int NUM_SRC   = 400,
  parameter int REG_BYTES = 2,
  parameter int SAFE_IDX  = 0,
  parameter logic [xbar_pkg::MAX_OUT-1:0] RSV_MASK  = xbar_pkg::ref_rsv_mask(),
  parameter logic [xbar_pkg::MAX_OUT-1:0] SKIP_MASK = xbar_pkg::ref_skip_mask(),
  localparam int DATA_W = REG_BYTES * 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = $clog2(NUM_OUT * REG_BYTES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_irq,
  input  logic [NUM_OUT-1:0]   hw_irq,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic [REG_BYTES-1:0] bus_be,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_OUT-1:0]   irq_out
);

  localparam logic [NUM_OUT-1:0] RSV = RSV_MASK[NUM_OUT-1:0];
  localparam logic [NUM_OUT-1:0] BYP = RSV | SKIP_MASK[NUM_OUT-1:0];

  logic [NUM_OUT-1:0]            reg_we;
  logic [NUM_OUT-1:0][IDX_W-1:0] route_idx;

  xbar_regbank #(
    .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .REG_BYTES(REG_BYTES),
    .SAFE_IDX(SAFE_IDX), .RSV(RSV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .reg_we(reg_we), .route_idx(route_idx)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    xbar_lane #(.NUM_SRC(NUM_SRC), .BYPASS(BYP[i])) u_lane (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .hw_req(hw_irq[i]),
      .sel_idx(route_idx[i]), .out_q(irq_out[i])
    );
  end

endmodule

// File: rtl/irq_xbar_chk.sv
module irq_xbar_chk #(
  parameter int NUM_OUT   = 160,
  parameter int NUM_SRC   = 400,
  parameter int REG_BYTES = 2,
  parameter logic [NUM_OUT-1:0] RSV = '0,
  parameter logic [NUM_OUT-1:0] BYP = '0,
  localparam int DATA_W = REG_BYTES * 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = $clog2(NUM_OUT * REG_BYTES) + 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_SRC-1:0]            src_irq,
  input logic [NUM_OUT-1:0]            hw_irq,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [REG_BYTES-1:0]          bus_be,
  input logic [NUM_OUT-1:0]            irq_out,
  input logic [NUM_OUT-1:0]            reg_we,
  input logic [NUM_OUT-1:0][IDX_W-1:0] route_idx
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic full_be, bad_addr;
  assign full_be  = &bus_be;
  assign bad_addr = (32'(bus_addr) % REG_BYTES) != 0 ||
                    32'(bus_addr) >= NUM_OUT * REG_BYTES;

  // R3
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_we));

  // R3
  wr_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_we) |-> bus_wr);

  // R4
  bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && full_be && 32'(bus_wdata) >= NUM_SRC) |-> (reg_we == '0));

  // R6
  rsv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we & RSV) == '0);

  // R8
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bad_addr) |-> (reg_we == '0));

  // R6 R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((irq_out ^ $past(hw_irq)) & BYP) == '0));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_route
    if (!BYP[i]) begin : g_on
      // R2
      route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_out[i] == $past(src_irq[route_idx[i]])));
    end
  end

endmodule

bind irq_xbar irq_xbar_chk #(
  .NUM_OUT(NUM_OUT), .NUM_SRC(NUM_SRC), .REG_BYTES(REG_BYTES),
  .RSV(RSV), .BYP(BYP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .hw_irq(hw_irq),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_be(bus_be), .irq_out(irq_out), .reg_we(reg_we), .route_idx(route_idx)
);

// File: tb/irq_xbar_test.sv
module irq_xbar_test;

  localparam int NO = 160;
  localparam int NS = 400;
  localparam int RB = 2;
  localparam int AW = $clog2(NO * RB) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0]   src_irq = '0;
  logic [NO-1:0]   hw_irq = '0;
  logic            bus_wr = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [15:0]     bus_wdata = '0;
  logic [1:0]      bus_be = '0;
  logic [15:0]     bus_rdata;
  logic [NO-1:0]   irq_out;

  int checks = 0, fails = 0;
  int exp_idx [NO];

  always #10 clk = ~clk;

  irq_xbar uut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .hw_irq(hw_irq),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic bit is_rsv(int i);
    return i inside {0, 1, 2, 3, 5, 6, 131, 132};
  endfunction
  function automatic bit is_skip(int i);
    return i inside {10, 133, 139, 140};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench view of a write: lane merge, range test, address rules.
  task automatic bwr(int addr, int data, logic [1:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = 16'(data); bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
    if (addr % RB == 0 && addr < NO * RB && !is_rsv(addr / RB)) begin
      int v = exp_idx[addr / RB];
      if (be[0]) v = (v & 'hFF00) | (data & 'h00FF);
      if (be[1]) v = (v & 'h00FF) | (data & 'hFF00);
      if (v < NS) exp_idx[addr / RB] = v;
    end
  endtask

  task automatic brd(int addr, output int val);
    @(negedge clk);
    bus_addr = AW'(addr);
    #1 val = int'(bus_rdata);
  endtask

  function automatic logic [NO-1:0] model_out();
    logic [NO-1:0] o;
    for (int i = 0; i < NO; i++)
      o[i] = (is_rsv(i) || is_skip(i)) ? hw_irq[i] : src_irq[exp_idx[i]];
    return o;
  endfunction

  // Inputs are already set; let one edge pass and compare.
  task automatic cmp_out(string req);
    @(posedge clk);
    @(negedge clk);
    chk(irq_out == model_out(), req, longint'(irq_out[63:0]), longint'(model_out() >> 0));
  endtask

  task automatic read_chk(int reg_i, string req);
    int v;
    brd(reg_i * RB, v);
    chk(v == (is_rsv(reg_i) ? 0 : exp_idx[reg_i]), req, v, exp_idx[reg_i]);
  endtask

  task automatic t_reset();
    int v;
    rst_n = 1'b0;
    src_irq = '1; hw_irq = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(irq_out == '0, "R1 outputs low in reset", longint'(irq_out[63:0]), 0);
    src_irq = '0; hw_irq = '0;
    rst_n = 1'b1;
    for (int i = 0; i < NO; i++) exp_idx[i] = 0;
    brd(0 * RB + 20 * RB, v);  chk(v == 0, "R1 reg20 reset", v, 0);
    brd(159 * RB, v);          chk(v == 0, "R1 reg159 reset", v, 0);
    src_irq[0] = 1'b1;
    cmp_out("R1 routed outputs follow source 0");
    src_irq = '0;
  endtask

  task automatic t_route();
    bwr(20 * RB, 399, 2'b11);
    bwr(21 * RB, 7, 2'b11);
    bwr(159 * RB, 250, 2'b11);
    bwr(40 * RB, 1, 2'b11);
    read_chk(20, "R3 readback 399");
    read_chk(21, "R3 readback 7");
    read_chk(159, "R3 readback 250");
    src_irq = '0;                    cmp_out("R2 all low");
    src_irq = '1;                    cmp_out("R2 all high");
    for (int k = 0; k < NS; k += 2) src_irq[k] = 1'b0;
    cmp_out("R2 alternating");
    foreach (exp_idx[i]) begin end
    src_irq = '0; src_irq[399] = 1'b1; cmp_out("R2 single 399");
    src_irq = '0; src_irq[7] = 1'b1;   cmp_out("R2 single 7");
    src_irq = '0; src_irq[250] = 1'b1; cmp_out("R2 single 250");
    src_irq = '0; src_irq[0] = 1'b1;   cmp_out("R2 single 0");
    // latency: change just after an edge, output must hold until the next edge
    @(negedge clk);
    src_irq = '0; src_irq[399] = 1'b1;
    #1 chk(irq_out[20] == 1'b0, "R2 no change before edge", irq_out[20], 0);
    @(posedge clk); #1;
    chk(irq_out[20] == 1'b1, "R2 change one clock later", irq_out[20], 1);
    src_irq = '0;
  endtask

  task automatic t_invalid();
    bwr(21 * RB, 400, 2'b11);
    read_chk(21, "R4 index 400 ignored");
    bwr(21 * RB, 'hFFFF, 2'b11);
    read_chk(21, "R4 index FFFF ignored");
    bwr(21 * RB, 399, 2'b11);
    read_chk(21, "R4 top index accepted");
  endtask

  task automatic t_bytes();
    bwr(30 * RB, 'h0005, 2'b11);
    bwr(30 * RB, 'h0100, 2'b10);
    read_chk(30, "R5 high lane only (0x105)");
    bwr(30 * RB, 'hEE33, 2'b01);
    read_chk(30, "R5 low lane only (0x133)");
    bwr(30 * RB, 'h0200, 2'b10);
    read_chk(30, "R5 merged 0x233 out of range ignored");
    src_irq = '0; src_irq['h133] = 1'b1;
    cmp_out("R5 route after lane writes");
    src_irq = '0;
  endtask

  task automatic t_reserved();
    int v;
    bwr(5 * RB, 9, 2'b11);
    brd(5 * RB, v); chk(v == 0, "R6 reserved reads 0", v, 0);
    src_irq = '1; hw_irq = '0;
    cmp_out("R6 sources ignored");
    chk(irq_out[5] == 1'b0, "R6 out5 low", irq_out[5], 0);
    hw_irq[5] = 1'b1; hw_irq[131] = 1'b1;
    cmp_out("R6 hard-wired passes");
    chk(irq_out[5] && irq_out[131], "R6 out5/131 high", irq_out[5], 1);
    hw_irq = '0; src_irq = '0;
  endtask

  task automatic t_skip();
    bwr(10 * RB, 12, 2'b11);
    read_chk(10, "R7 skip reg readback");
    src_irq = '0; src_irq[12] = 1'b1; hw_irq = '0;
    cmp_out("R7 skip ignores register");
    chk(irq_out[10] == 1'b0, "R7 out10 low", irq_out[10], 0);
    hw_irq[10] = 1'b1; src_irq = '0;
    cmp_out("R7 skip follows hard-wired");
    hw_irq = '0;
  endtask

  task automatic t_window();
    int v;
    bwr(NO * RB, 3, 2'b11);
    bwr(41, 3, 2'b11);
    brd(NO * RB, v); chk(v == 0, "R8 outside window reads 0", v, 0);
    brd(41, v);      chk(v == 0, "R8 misaligned reads 0", v, 0);
    read_chk(20, "R8 reg20 unchanged");
    read_chk(0 + 159, "R8 reg159 unchanged");
    cmp_out("R8 routing unchanged");
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_route();
    t_invalid();
    t_bytes();
    t_reserved();
    t_skip();
    t_window();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule